// File: doc/BRIEF.md
# Three-Neuron Binary Hopfield Recall Engine

This block is a small associative-memory engine built around three binary neurons with symmetric signed weights. A host first programs three shared pair weights, three self-weights and one firing threshold per neuron through a register write port, while the engine is idle. It then presents a 3-bit starting pattern and pulses start. The engine then refines that pattern until it stops changing, and it lands on whichever stored pattern the weights describe.

Each update cycle is split into three stages, one clock each. Stage a re-evaluates neuron 1, stage b neuron 2 and stage c neuron 3. A stage always uses the bits that earlier stages have already rewritten. A neuron fires when the weighted sum of the current state bits reaches its threshold. The engine stops with a converged flag after the first full cycle in which no bit moved. If it reaches a cycle limit first, it stops with a timeout flag instead. Every stage is reported on a trace output, so the host can follow the path through intermediate patterns.

Top module: `hopfield_recall`

## Requirements
- R1: After reset, busy, converged, timedOut and traceValid are 0, and stateOut and cycleCount are 0.
- R2: A write with wrEn high while busy is 0 stores wrData into the register picked by wrAddr: 0 is the neuron 1-2 pair weight, 1 is the 1-3 pair weight, 2 is the 2-3 pair weight, 3, 4 and 5 are the self-weights of neurons 1, 2 and 3, and 6, 7 and 8 are the thresholds of neurons 1, 2 and 3. All are 16-bit two's complement. Writes while busy is 1 have no effect.
- R3: The neuron being updated becomes 1 when the sum of the weights of the neurons whose state bit is 1 is greater than or equal to its threshold, and becomes 0 otherwise. The same pair weight serves both directions.
- R4: stateOut bit 2 is x1, bit 1 is x2 and bit 0 is x3. Stage 0 (a) updates bit 2, stage 1 (b) bit 1 and stage 2 (c) bit 0. A stage changes no other bit, and each stage takes one clock.
- R5: Each stage evaluates against the state as already rewritten by the earlier stages of the same cycle.
- R6: When a full cycle ends with no bit changed, the engine sets converged, clears busy and leaves stateOut holding the pattern. cycleCount then gives the number of cycles run, counting the quiet one.
- R7: When cycle number MaxCycles (default 15) ends with a change, the engine sets timedOut instead of converged, clears busy, and cycleCount equals MaxCycles. converged and timedOut are never both 1.
- R8: A start pulse while busy is 1 is ignored. The run in progress continues unchanged.
- R9: The self-weight of the neuron being updated counts in its sum only when that neuron's current bit is 1.
- R10: For the clock after each stage, traceValid is 1, traceStage gives the stage index (0, 1 or 2) and traceState gives the full state after that stage.
- R11: With pair weights 410, 81 and -394, zero self-weights and all thresholds -200, every start pattern ends at 110. With pair weights 110, 816 and 458 and all thresholds 600, patterns 000, 100, 010 and 110 end at 000, and the other four end at 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index (see R2) |
| wrData | input | 16 | Signed register value |
| startPulse | input | 1 | Begin a recall from initState |
| initState | input | 3 | Starting pattern, bit 2 is x1 |
| busy | output | 1 | Recall in progress |
| stateOut | output | 3 | Current pattern |
| converged | output | 1 | Last run settled |
| timedOut | output | 1 | Last run hit the cycle limit |
| cycleCount | output | 4 | Cycles run in the last recall |
| traceValid | output | 1 | One stage just completed |
| traceStage | output | 2 | Index of that stage |
| traceState | output | 3 | Pattern after that stage |

## Verification
A wrong weight select, a wrong threshold, or a stage that touches the wrong bit shows up on traceState one clock after that stage. The trace is compared against an independent model at every stage, so a single wrong decision is caught in the stage where it happens, not only in the final pattern. A control fault in the change tracking or the cycle limit shows up as a wrong flag or count when busy falls. The self-oscillating setup drives the limit path, and a write or start issued in the middle of a run shows whether the engine shields itself from the host while busy.

// File: rtl/hopfield_pkg.sv
package hopfield_pkg;
  localparam int NEURONS = 3;
  localparam int STAGE_W = 2;

  typedef struct packed {
    logic               load;
    logic               step;
    logic [STAGE_W-1:0] stage;
  } dpCtrlT;
endpackage

// File: rtl/hopfield_datapath.sv
module hopfield_datapath
  import hopfield_pkg::*;
#(
  parameter int WeightW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrlT                     ctrl,
  input  logic                       idle,
  input  logic [NEURONS-1:0]         initState,
  input  logic                       wrEn,
  input  logic [3:0]                 wrAddr,
  input  logic signed [WeightW-1:0]  wrData,
  output logic [NEURONS-1:0]         stateQ,
  output logic                       stageChanged,
  output logic                       traceValid,
  output logic [STAGE_W-1:0]         traceStage,
  output logic [NEURONS-1:0]         traceState
);
  localparam int SumW = WeightW + 2;

  logic signed [WeightW-1:0] pairW [NEURONS];
  logic signed [WeightW-1:0] selfW [NEURONS];
  logic signed [WeightW-1:0] thrW  [NEURONS];

  logic signed [SumW-1:0] terms [NEURONS];
  logic signed [SumW-1:0] sumVal;
  logic signed [SumW-1:0] thrVal;
  logic [NEURONS-1:0]     stageMask;
  logic [NEURONS-1:0]     nextState;
  logic                   fireBit;

  // Weight between the neuron under update and neuron j (both 0-based)
  for (genvar j = 0; j < NEURONS; j++) begin : g_term
    logic signed [WeightW-1:0] wSel;
    always_comb begin
      unique case ({ctrl.stage, 2'(j)})
        4'b0000: wSel = selfW[0];
        4'b0101: wSel = selfW[1];
        4'b1010: wSel = selfW[2];
        4'b0001, 4'b0100: wSel = pairW[0];
        4'b0010, 4'b1000: wSel = pairW[1];
        4'b0110, 4'b1001: wSel = pairW[2];
        default: wSel = '0;
      endcase
      terms[j] = stateQ[NEURONS-1-j] ? SumW'(wSel) : '0;
    end
  end

  always_comb begin
    unique case (ctrl.stage)
      2'd0:    thrVal = SumW'(thrW[0]);
      2'd1:    thrVal = SumW'(thrW[1]);
      2'd2:    thrVal = SumW'(thrW[2]);
      default: thrVal = '0;
    endcase
    sumVal       = terms[0] + terms[1] + terms[2];
    fireBit      = (sumVal >= thrVal);
    stageMask    = 3'b100 >> ctrl.stage;
    nextState    = (stateQ & ~stageMask) | (fireBit ? stageMask : '0);
    stageChanged = ctrl.step && (nextState != stateQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NEURONS; i++) begin
        pairW[i] <= '0;
        selfW[i] <= '0;
        thrW[i]  <= '0;
      end
    end else if (wrEn && idle) begin
      unique case (wrAddr)
        4'd0: pairW[0] <= wrData;
        4'd1: pairW[1] <= wrData;
        4'd2: pairW[2] <= wrData;
        4'd3: selfW[0] <= wrData;
        4'd4: selfW[1] <= wrData;
        4'd5: selfW[2] <= wrData;
        4'd6: thrW[0]  <= wrData;
        4'd7: thrW[1]  <= wrData;
        4'd8: thrW[2]  <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= '0;
      traceValid <= 1'b0;
      traceStage <= '0;
      traceState <= '0;
    end else begin
      traceValid <= ctrl.step;
      if (ctrl.load) begin
        stateQ <= initState;
      end else if (ctrl.step) begin
        stateQ     <= nextState;
        traceStage <= ctrl.stage;
        traceState <= nextState;
      end
    end
  end

  // R4: a stage may only move its own bit
  assert_one_bit_per_stage_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> ((stateQ ^ $past(stateQ)) & ~(3'b100 >> $past(ctrl.stage))) == '0);

  // R8: without load or step the pattern holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> $stable(stateQ));

  // R10: the trace mirrors the state after each stage
  assert_trace_matches_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> (traceValid && traceState == stateQ));
endmodule

// File: rtl/hopfield_control.sv
module hopfield_control
  import hopfield_pkg::*;
#(
  parameter int MaxCycles = 15,
  localparam int CntW = $clog2(MaxCycles + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            stageChanged,
  output dpCtrlT          ctrl,
  output logic            busy,
  output logic            converged,
  output logic            timedOut,
  output logic [CntW-1:0] cycleCount
);
  typedef enum logic {S_IDLE, S_RUN} fsmT;

  fsmT                fsmQ;
  logic [STAGE_W-1:0] stageQ;
  logic               changedAcc;
  logic               anyChange;
  logic [CntW-1:0]    cycleNext;

  assign busy       = (fsmQ == S_RUN);
  assign ctrl.load  = (fsmQ == S_IDLE) && startPulse;
  assign ctrl.step  = (fsmQ == S_RUN);
  assign ctrl.stage = stageQ;
  assign anyChange  = changedAcc || stageChanged;
  assign cycleNext  = cycleCount + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsmQ       <= S_IDLE;
      stageQ     <= '0;
      changedAcc <= 1'b0;
      converged  <= 1'b0;
      timedOut   <= 1'b0;
      cycleCount <= '0;
    end else begin
      unique case (fsmQ)
        S_IDLE: if (startPulse) begin
          fsmQ       <= S_RUN;
          stageQ     <= '0;
          changedAcc <= 1'b0;
          converged  <= 1'b0;
          timedOut   <= 1'b0;
          cycleCount <= '0;
        end
        S_RUN: begin
          if (stageQ == STAGE_W'(NEURONS - 1)) begin
            cycleCount <= cycleNext;
            stageQ     <= '0;
            changedAcc <= 1'b0;
            if (!anyChange) begin
              converged <= 1'b1;
              fsmQ      <= S_IDLE;
            end else if (cycleNext == CntW'(MaxCycles)) begin
              timedOut <= 1'b1;
              fsmQ     <= S_IDLE;
            end
          end else begin
            stageQ     <= stageQ + 1'b1;
            changedAcc <= anyChange;
          end
        end
        default: fsmQ <= S_IDLE;
      endcase
    end
  end

  // R7: the two end flags exclude each other
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(converged && timedOut));

  // R7: the count never passes the limit
  assert_cycle_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cycleCount <= CntW'(MaxCycles));

  // R6: converged only appears as the engine goes idle
  assert_converge_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(converged) |-> !busy);

  // R8: start in mid-run does not restart the stage sequence
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && stageQ != 2'd2) |=> (stageQ == $past(stageQ) + 2'd1));
endmodule

// File: rtl/hopfield_recall.sv
module hopfield_recall
  import hopfield_pkg::*;
#(
  parameter int WeightW   = 16,
  parameter int MaxCycles = 15,
  localparam int CntW = $clog2(MaxCycles + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [3:0]                wrAddr,
  input  logic signed [WeightW-1:0] wrData,
  input  logic                      startPulse,
  input  logic [NEURONS-1:0]        initState,
  output logic                      busy,
  output logic [NEURONS-1:0]        stateOut,
  output logic                      converged,
  output logic                      timedOut,
  output logic [CntW-1:0]           cycleCount,
  output logic                      traceValid,
  output logic [STAGE_W-1:0]        traceStage,
  output logic [NEURONS-1:0]        traceState
);
  dpCtrlT ctrl;
  logic   stageChanged;

  hopfield_control #(.MaxCycles(MaxCycles)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .stageChanged (stageChanged),
    .ctrl         (ctrl),
    .busy         (busy),
    .converged    (converged),
    .timedOut     (timedOut),
    .cycleCount   (cycleCount)
  );

  hopfield_datapath #(.WeightW(WeightW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .idle         (!busy),
    .initState    (initState),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .stateQ       (stateOut),
    .stageChanged (stageChanged),
    .traceValid   (traceValid),
    .traceStage   (traceStage),
    .traceState   (traceState)
  );
endmodule

// File: tb/sim_hopfield_recall.sv
module sim_hopfield_recall;
  localparam int ClkPeriod = 10;
  localparam int MaxCyc    = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic signed [15:0] wrData = '0;
  logic        startPulse = 1'b0;
  logic [2:0]  initState = '0;
  logic        busy, converged, timedOut, traceValid;
  logic [2:0]  stateOut, traceState;
  logic [3:0]  cycleCount;
  logic [1:0]  traceStage;

  int tests = 0;
  int fails = 0;
  int ticks = 0;

  // model registers: pair 12,13,23 ; self 1..3 ; thresholds 1..3
  int mPair [3];
  int mSelf [3];
  int mThr  [3];

  // {set, init, expected final}
  localparam logic [6:0] Vecs [16] = '{
    {1'b0,3'b000,3'b110}, {1'b0,3'b001,3'b110}, {1'b0,3'b010,3'b110}, {1'b0,3'b011,3'b110},
    {1'b0,3'b100,3'b110}, {1'b0,3'b101,3'b110}, {1'b0,3'b110,3'b110}, {1'b0,3'b111,3'b110},
    {1'b1,3'b000,3'b000}, {1'b1,3'b001,3'b101}, {1'b1,3'b010,3'b000}, {1'b1,3'b011,3'b101},
    {1'b1,3'b100,3'b000}, {1'b1,3'b101,3'b101}, {1'b1,3'b110,3'b000}, {1'b1,3'b111,3'b101}
  };

  hopfield_recall #(.WeightW(16), .MaxCycles(MaxCyc)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startPulse(startPulse), .initState(initState), .busy(busy), .stateOut(stateOut),
    .converged(converged), .timedOut(timedOut), .cycleCount(cycleCount),
    .traceValid(traceValid), .traceStage(traceStage), .traceState(traceState)
  );

  always #(ClkPeriod/2) clk = ~clk;

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog (all): actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pairOf(input int a, input int b);
    if ((a == 0 && b == 1) || (a == 1 && b == 0)) return mPair[0];
    if ((a == 0 && b == 2) || (a == 2 && b == 0)) return mPair[1];
    return mPair[2];
  endfunction

  // R3/R5/R9: model of one stage on neuron n (0-based), bit 2-n
  function automatic logic [2:0] modelStage(input int n, input logic [2:0] st);
    int acc = 0;
    logic [2:0] r = st;
    for (int j = 0; j < 3; j++)
      if (st[2-j]) acc += (j == n) ? mSelf[n] : pairOf(n, j);
    r[2-n] = (acc >= mThr[n]);
    return r;
  endfunction

  task automatic writeReg(input int addr, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 16'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadAll(input int p0, input int p1, input int p2,
                         input int s0, input int s1, input int s2,
                         input int t0, input int t1, input int t2);
    writeReg(0, p0); writeReg(1, p1); writeReg(2, p2);
    writeReg(3, s0); writeReg(4, s1); writeReg(5, s2);
    writeReg(6, t0); writeReg(7, t1); writeReg(8, t2);
    mPair = '{p0, p1, p2}; mSelf = '{s0, s1, s2}; mThr = '{t0, t1, t2};
  endtask

  // Run one recall, check every trace step against the model, return final
  task automatic runRecall(input logic [2:0] init, input bit disturb, output logic [2:0] fin);
    logic [2:0] mState = init;
    bit mChanged = 0;
    int mCycles = 0;
    int mStage = 0;
    bit mConv = 0, mTo = 0, done = 0;
    int steps = 0;
    int traceErr = 0;
    @(negedge clk);
    initState = init; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    while (!done) begin
      logic [2:0] nxt;
      @(negedge clk);
      steps++;
      if (disturb && steps == 2) begin
        startPulse = 1'b1; initState = ~init;  // R8: ignored while busy
        wrEn = 1'b1; wrAddr = 4'd6; wrData = 16'sd30000; // R2: ignored while busy
      end else begin
        startPulse = 1'b0; wrEn = 1'b0;
      end
      nxt = modelStage(mStage, mState);
      if (nxt != mState) mChanged = 1;
      // R10, R4, R5: trace per stage
      if (!traceValid || traceStage != 2'(mStage) || traceState != nxt) traceErr++;
      mState = nxt;
      if (mStage == 2) begin
        mCycles++;
        if (!mChanged) begin mConv = 1; done = 1; end
        else if (mCycles == MaxCyc) begin mTo = 1; done = 1; end
        mChanged = 0; mStage = 0;
      end else mStage++;
      if (steps > 3 * MaxCyc + 3) done = 1;
    end
    startPulse = 1'b0; wrEn = 1'b0;
    check("R10 trace mismatches", traceErr, 0);
    check("R6 busy low at end", int'(busy), 0);
    check("R6 converged", int'(converged), int'(mConv));
    check("R7 timedOut", int'(timedOut), int'(mTo));
    check("R6 cycleCount", int'(cycleCount), mCycles);
    check("R5 final vs model", int'(stateOut), int'(mState));
    fin = stateOut;
  endtask

  initial begin
    logic [2:0] fin;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 converged", int'(converged), 0);
    check("R1 timedOut", int'(timedOut), 0);
    check("R1 traceValid", int'(traceValid), 0);
    check("R1 stateOut", int'(stateOut), 0);
    check("R1 cycleCount", int'(cycleCount), 0);
    rstN = 1'b1;

    // R11, R3: table of both stored weight sets over all start patterns
    for (int i = 0; i < 16; i++) begin
      if (i == 0) loadAll(410, 81, -394, 0, 0, 0, -200, -200, -200);
      if (i == 8) loadAll(110, 816, 458, 0, 0, 0, 600, 600, 600);
      runRecall(Vecs[i][5:3], 1'b0, fin);
      check($sformatf("R11 final set%0d init %b", Vecs[i][6], Vecs[i][5:3]),
            int'(fin), int'(Vecs[i][2:0]));
    end

    // R6: directed count, 000 -> 100 -> 110 then one quiet cycle
    loadAll(410, 81, -394, 0, 0, 0, -200, -200, -200);
    runRecall(3'b000, 1'b0, fin);
    check("R6 two cycles from 000", int'(cycleCount), 2);
    runRecall(3'b110, 1'b0, fin);
    check("R6 one cycle from stored pattern", int'(cycleCount), 1);

    // R8 and R2: start and write during a run have no effect
    runRecall(3'b000, 1'b1, fin);
    check("R8 final despite mid-run start", int'(fin), 3'b110);
    runRecall(3'b000, 1'b0, fin);
    check("R2 busy write to threshold dropped", int'(fin), 3'b110);

    // R9, R7: negative self-weight makes x1 toggle every cycle
    loadAll(0, 0, 0, -1000, 0, 0, -100, 100, 100);
    runRecall(3'b000, 1'b0, fin);
    check("R7 timeout flag", int'(timedOut), 1);
    check("R7 cycleCount at limit", int'(cycleCount), MaxCyc);
    check("R9 self-term toggles x1", int'(fin), 3'b100);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule